// File: doc/BRIEF.md
# Transmit Self-Test and DAC Pattern Source

This block feeds the transmit path with test stimulus in place of live traffic. It makes two kinds of word. Bit words carry serial data for the equalizing filter: clock patterns and pseudorandom sequences. Thermometer words drive the 15 unit segments of the output DAC directly: a triangular code ramp, random codes, and a toggle of one segment. A seventh mode forwards 32-bit words from the host stream without changes, so that arbitrary DAC stimulus can be applied.

Every output word is offered on a valid/ready stream. A word stays on the port, unchanged, until the consumer takes it. The host stream in direct mode is joined straight to the output stream, so back-pressure passes through it with no storage. The mode, segment index and hold length are plain control inputs. A new mode is adopted only between words, and adopting it restarts all pattern state.

Top module: `tx_test_patgen`

## Requirements
- R1: After reset the block is in clock mode (code 0). It presents `out_valid`=1, `out_data`=32'hAAAA_AAAA and `out_kind`=0, with `host_ready`=0.
- R2: The mode codes are 0 clock, 1 PRBS7, 2 PRBS31, 3 ramp, 4 random, 5 toggle, 6 direct and 7 half-rate clock. A new `cfg_mode` value is adopted only at a clock edge where the current word is accepted or no word is offered. While a word is stalled, the mode does not change.
- R3: Clock mode outputs 32'hAAAA_AAAA and half-rate clock mode outputs 32'hCCCC_CCCC, both with `out_kind`=0 (bit 0 is transmitted first).
- R4: PRBS7 mode uses x^7+x^6+1. Each step computes new = s[6]^s[5] and shifts it into s[0]. The register starts at all ones. Each word holds 32 successive new bits with the earliest in bit 0, and `out_kind`=0.
- R5: PRBS31 mode is the same as R4 but uses x^31+x^28+1 (new = s[30]^s[27]).
- R6: Adopting a mode resets the generator state. A return to PRBS mode restarts the sequence from the all-ones seed.
- R7: Ramp mode outputs thermometer words (`out_kind`=1, bits [c-1:0] set for code c, bits [31:15] zero). The code runs 0,1,…,15,14,…,1,0,1,… and no end value repeats.
- R8: In ramp mode each code is held for `cfg_hold`+1 accepted words.
- R9: Random mode outputs a thermometer word of code s[3:0] from the PRBS31 register (seeded all ones), then advances that register 32 steps per accepted word.
- R10: Toggle mode with effective index k = min(`cfg_seg`,14) holds segments below k at 1 and above k at 0. Segment k starts at 0 and inverts on every accepted word, so successive words differ in one bit.
- R11: In direct mode `out_data`=`host_data`, `out_valid`=`host_valid`, `host_ready`=`out_ready` and `out_kind`=2. In every other mode `host_ready` is 0.
- R12: A generated word offered with `out_ready` low holds its data and kind until it is accepted.
- R13: A pseudorandom bit word is never all zeros. A register that reaches all zeros is reloaded with the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 3 | Requested pattern mode |
| cfg_seg | input | 4 | Segment index for toggle mode |
| cfg_hold | input | 8 | Ramp hold length minus one |
| host_data | input | 32 | Direct-mode word from the host |
| host_valid | input | 1 | Host word valid |
| host_ready | output | 1 | Host word accepted |
| out_data | output | 32 | Pattern word |
| out_kind | output | 2 | 0 bit word, 1 thermometer word, 2 raw host word |
| out_valid | output | 1 | Pattern word valid |
| out_ready | input | 1 | Consumer takes the word |

## Verification
The bench targets the ramp turning points. A counter that repeated 15 or 0, or that wrapped instead of turning back, would put a wrong code in the compared stream, with hold lengths of one and three words. It runs PRBS modes, switches away and then comes back, which catches a design that resumes its old state instead of the seed. It stalls a word while the mode request changes, which exposes a design that switches in the middle of a word or lets a stalled word change. The toggle tests include index 15, which must clamp to 14. Direct mode is run with gaps in the host stream, and `host_ready` is checked to stay low outside direct mode.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [2:0] {
    MODE_CLK    = 3'd0,
    MODE_PRBS7  = 3'd1,
    MODE_PRBS31 = 3'd2,
    MODE_RAMP   = 3'd3,
    MODE_RAND   = 3'd4,
    MODE_TOGGLE = 3'd5,
    MODE_DIRECT = 3'd6,
    MODE_CLK2   = 3'd7
  } tpg_mode_e;

  typedef enum logic [1:0] {
    KIND_BITS  = 2'd0,
    KIND_THERM = 2'd1,
    KIND_RAW   = 2'd2
  } tpg_kind_e;
endpackage

// File: rtl/tpg_prbs_core.sv
module tpg_prbs_core #(
  parameter int WORD_W   = 32,
  parameter int LONG_W   = 31,
  parameter int LONG_T2  = 28,
  parameter int SHORT_W  = 7,
  parameter int SHORT_T2 = 6,
  parameter int CODE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  input  logic              sel_long,
  output logic [WORD_W-1:0] word_o,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [LONG_W-1:0] SHORT_MASK = {{(LONG_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};
  localparam logic [LONG_W-1:0] SEED = '1;

  logic [LONG_W-1:0] st_q, walk, nxt;
  logic              fb;

  // unrolled: one word's worth of shift steps per advance
  always_comb begin
    walk   = st_q;
    word_o = '0;
    fb     = 1'b0;
    for (int i = 0; i < WORD_W; i++) begin
      fb = sel_long ? (walk[LONG_W-1] ^ walk[LONG_T2-1])
                    : (walk[SHORT_W-1] ^ walk[SHORT_T2-1]);
      word_o[i] = fb;
      walk = {walk[LONG_W-2:0], fb};
    end
    nxt = sel_long ? walk : (walk & SHORT_MASK);
  end

  assign code_o = st_q[CODE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      st_q <= SEED;
    end else if (advance) begin
      st_q <= (nxt == '0) ? SEED : nxt;  // lock-up escape
    end
  end
endmodule

// File: rtl/tpg_ramp_core.sv
module tpg_ramp_core #(
  parameter int CODE_W = 4,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  input  logic [HOLD_W-1:0] hold_len,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

  logic [CODE_W-1:0] code_q;
  logic [HOLD_W-1:0] cnt_q;
  logic              up_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      code_q <= '0;
      cnt_q  <= '0;
      up_q   <= 1'b1;
    end else if (advance) begin
      if (cnt_q == hold_len) begin
        cnt_q <= '0;
        if (up_q) begin
          if (code_q == TOP) begin
            code_q <= TOP - 1'b1;
            up_q   <= 1'b0;
          end else begin
            code_q <= code_q + 1'b1;
          end
        end else begin
          if (code_q == '0) begin
            code_q <= {{(CODE_W-1){1'b0}}, 1'b1};
            up_q   <= 1'b1;
          end else begin
            code_q <= code_q - 1'b1;
          end
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign code_o = code_q;
endmodule

// File: rtl/tpg_therm_enc.sv
module tpg_therm_enc #(
  parameter int SEGS   = 15,
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [SEGS-1:0]   therm_o
);
  for (genvar g = 0; g < SEGS; g++) begin : g_seg
    assign therm_o[g] = (code_i > CODE_W'(g));
  end
endmodule

// File: rtl/tx_test_patgen.sv
module tx_test_patgen
  import tpg_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SEGS   = 15,
  parameter int HOLD_W = 8,
  localparam int CODE_W = $clog2(SEGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_mode,
  input  logic [CODE_W-1:0] cfg_seg,
  input  logic [HOLD_W-1:0] cfg_hold,
  input  logic [WORD_W-1:0] host_data,
  input  logic              host_valid,
  output logic              host_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [1:0]        out_kind,
  output logic              out_valid,
  input  logic              out_ready
);
  localparam logic [CODE_W-1:0] SEG_MAX = CODE_W'(SEGS - 1);

  tpg_mode_e         act_mode;
  logic              at_boundary, mode_sw, accept;
  logic              prbs_on, tog_q;
  logic [WORD_W-1:0] prbs_word;
  logic [CODE_W-1:0] rand_code, ramp_code, seg_eff;
  logic [SEGS-1:0]   ramp_therm, rand_therm, seg_therm, tog_word;

  assign at_boundary = !out_valid || out_ready;
  assign mode_sw     = at_boundary && (cfg_mode != 3'(act_mode));
  assign accept      = out_valid && out_ready;
  assign prbs_on     = (act_mode == MODE_PRBS7) || (act_mode == MODE_PRBS31) ||
                       (act_mode == MODE_RAND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_mode <= MODE_CLK;
      tog_q    <= 1'b0;
    end else if (mode_sw) begin
      act_mode <= tpg_mode_e'(cfg_mode);
      tog_q    <= 1'b0;
    end else if (accept && act_mode == MODE_TOGGLE) begin
      tog_q    <= !tog_q;
    end
  end

  tpg_prbs_core #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_prbs (
    .clk(clk), .rst_n(rst_n), .restart(mode_sw), .advance(accept && prbs_on),
    .sel_long(act_mode != MODE_PRBS7), .word_o(prbs_word), .code_o(rand_code)
  );

  tpg_ramp_core #(.CODE_W(CODE_W), .HOLD_W(HOLD_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .restart(mode_sw),
    .advance(accept && act_mode == MODE_RAMP), .hold_len(cfg_hold), .code_o(ramp_code)
  );

  assign seg_eff = (cfg_seg > SEG_MAX) ? SEG_MAX : cfg_seg;

  tpg_therm_enc #(.SEGS(SEGS), .CODE_W(CODE_W)) u_enc_ramp (.code_i(ramp_code), .therm_o(ramp_therm));
  tpg_therm_enc #(.SEGS(SEGS), .CODE_W(CODE_W)) u_enc_rand (.code_i(rand_code), .therm_o(rand_therm));
  tpg_therm_enc #(.SEGS(SEGS), .CODE_W(CODE_W)) u_enc_seg  (.code_i(seg_eff),   .therm_o(seg_therm));

  always_comb begin
    tog_word          = seg_therm;
    tog_word[seg_eff] = tog_q;
  end

  always_comb begin
    out_valid  = 1'b1;
    out_data   = '0;
    out_kind   = KIND_BITS;
    host_ready = 1'b0;
    unique case (act_mode)
      MODE_CLK:    out_data = {(WORD_W/2){2'b10}};
      MODE_CLK2:   out_data = {(WORD_W/4){4'b1100}};
      MODE_PRBS7,
      MODE_PRBS31: out_data = prbs_word;
      MODE_RAMP: begin
        out_kind            = KIND_THERM;
        out_data[SEGS-1:0]  = ramp_therm;
      end
      MODE_RAND: begin
        out_kind            = KIND_THERM;
        out_data[SEGS-1:0]  = rand_therm;
      end
      MODE_TOGGLE: begin
        out_kind            = KIND_THERM;
        out_data[SEGS-1:0]  = tog_word;
      end
      MODE_DIRECT: begin
        out_kind   = KIND_RAW;
        out_valid  = host_valid;
        out_data   = host_data;
        host_ready = out_ready;
      end
      default: out_data = '0;
    endcase
  end
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker
  import tpg_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SEGS   = 15,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input tpg_mode_e         act_mode,
  input logic [CODE_W-1:0] cfg_seg,
  input logic [WORD_W-1:0] host_data,
  input logic              host_valid,
  input logic              host_ready,
  input logic [WORD_W-1:0] out_data,
  input logic [1:0]        out_kind,
  input logic              out_valid,
  input logic              out_ready
);
  logic [SEGS:0] th;
  assign th = {1'b0, out_data[SEGS-1:0]};

  a_r11_direct_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (out_kind == KIND_RAW) |->
      (out_valid == host_valid && out_data == host_data && host_ready == out_ready));

  a_r11_host_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (out_kind != KIND_RAW) |-> !host_ready);

  a_r12_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && out_kind != KIND_RAW) |=>
      ($stable(out_data) && $stable(out_kind)));

  a_r2_mode_held_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (act_mode == $past(act_mode)));

  a_r7_therm_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (out_kind == KIND_THERM) |->
      (out_data[WORD_W-1:SEGS] == '0 && (th & (th + 1'b1)) == '0));

  a_r10_single_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == MODE_TOGGLE && out_valid && out_ready) |=>
      (act_mode != MODE_TOGGLE || cfg_seg != $past(cfg_seg) ||
       $countones(out_data ^ $past(out_data)) == 1));

  a_r13_prbs_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == MODE_PRBS7 || act_mode == MODE_PRBS31) |-> (out_data != '0));
endmodule

bind tx_test_patgen tpg_checker #(.WORD_W(WORD_W), .SEGS(SEGS), .CODE_W(CODE_W)) u_tpg_checker (
  .clk(clk), .rst_n(rst_n), .act_mode(act_mode), .cfg_seg(cfg_seg),
  .host_data(host_data), .host_valid(host_valid), .host_ready(host_ready),
  .out_data(out_data), .out_kind(out_kind), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/tx_test_patgen_test.sv
module tx_test_patgen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_mode = 3'd0;
  logic [3:0]  cfg_seg = 4'd0;
  logic [7:0]  cfg_hold = 8'd0;
  logic [31:0] host_data = '0;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic [31:0] out_data;
  logic [1:0]  out_kind;
  logic        out_valid;
  logic        out_ready = 1'b1;

  int checks = 0, errors = 0;
  bit mon_en = 1'b0;
  logic [33:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = !clk;

  tx_test_patgen uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_seg(cfg_seg), .cfg_hold(cfg_hold),
    .host_data(host_data), .host_valid(host_valid), .host_ready(host_ready),
    .out_data(out_data), .out_kind(out_kind), .out_valid(out_valid), .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] therm(input int c);
    return (32'd1 << c) - 32'd1;
  endfunction

  function automatic logic [31:0] prbs_word(inout logic [30:0] s, input bit lng);
    logic [31:0] w;
    logic nb;
    for (int i = 0; i < 32; i++) begin
      nb = lng ? (s[30] ^ s[27]) : (s[6] ^ s[5]);
      w[i] = nb;
      s = {s[29:0], nb};
    end
    return w;
  endfunction

  // monitor: pops one expected item per accepted word
  always @(negedge clk) begin
    if (mon_en && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "extra", {out_kind, out_data}, '0);
      end else begin
        logic [33:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({out_kind, out_data} == e, t, {out_kind, out_data}, e);
        if (t == "R4" || t == "R5")
          check(out_data != 0, "R13", {out_kind, out_data}, e);
      end
    end
  end

  task automatic push(input logic [1:0] k, input logic [31:0] d, input string t);
    exp_q.push_back({k, d});
    tag_q.push_back(t);
  endtask

  task automatic fill(input int m, input int n, input string t);
    logic [30:0] s = '1;
    int code = 0, cnt = 0, ph = 0, k;
    bit up = 1'b1;
    k = (cfg_seg > 14) ? 14 : int'(cfg_seg);
    for (int i = 0; i < n; i++) begin
      case (m)
        0: push(2'd0, 32'hAAAA_AAAA, t);
        7: push(2'd0, 32'hCCCC_CCCC, t);
        1, 2: push(2'd0, prbs_word(s, m == 2), t);
        3: begin
          push(2'd1, therm(code), t);
          if (cnt == int'(cfg_hold)) begin
            cnt = 0;
            if (up) begin
              if (code == 15) begin code = 14; up = 1'b0; end else code++;
            end else begin
              if (code == 0) begin code = 1; up = 1'b1; end else code--;
            end
          end else cnt++;
        end
        4: begin
          logic [31:0] dummy;
          push(2'd1, therm(int'(s[3:0])), t);
          dummy = prbs_word(s, 1'b1);
        end
        5: begin
          push(2'd1, (therm(k) & ~(32'd1 << k)) | (32'(ph) << k), t);
          ph ^= 1;
        end
        default: ;
      endcase
    end
  endtask

  task automatic switch_to(input logic [2:0] m);
    @(posedge clk); #1;
    mon_en = 1'b0; cfg_mode = m; out_ready = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic run_mode(input logic [2:0] m, input int n, input string t, input bit stall);
    int cyc = 0;
    switch_to(m);
    fill(int'(m), n, t);
    mon_en = 1'b1;
    while (exp_q.size() > 0) begin
      @(posedge clk); #1;
      cyc++;
      if (stall) out_ready = (cyc % 3 != 2);
    end
    out_ready = 1'b1;
    mon_en = 1'b0;
  endtask

  initial begin
    #(10 * 150000);
    check(1'b0, "watchdog", '0, '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(out_valid && out_kind == 2'd0 && out_data == 32'hAAAA_AAAA && !host_ready,
          "R1", {out_kind, out_data}, {2'd0, 32'hAAAA_AAAA});

    run_mode(3'd7, 8, "R3", 1'b1);
    run_mode(3'd1, 20, "R4", 1'b1);
    run_mode(3'd0, 4, "R3", 1'b0);
    run_mode(3'd1, 6, "R6", 1'b0);       // R6: restart from seed
    run_mode(3'd2, 20, "R5", 1'b1);
    cfg_hold = 8'd0;
    run_mode(3'd3, 40, "R7", 1'b0);
    run_mode(3'd4, 20, "R9", 1'b0);
    cfg_hold = 8'd2;
    run_mode(3'd3, 70, "R8", 1'b1);

    // R2 / R12: stalled ramp word must not change nor switch mode
    begin
      logic [33:0] held;
      @(posedge clk); #1;
      out_ready = 1'b0; cfg_mode = 3'd0;
      @(negedge clk);
      held = {out_kind, out_data};
      repeat (3) @(negedge clk);
      check({out_kind, out_data} == held, "R12", {out_kind, out_data}, held);
      check(out_kind == 2'd1, "R2", {out_kind, out_data}, held);
      @(posedge clk); #1;
      out_ready = 1'b1;
      @(posedge clk); #1;
      @(negedge clk);
      check({out_kind, out_data} == {2'd0, 32'hAAAA_AAAA}, "R2", {out_kind, out_data},
            {2'd0, 32'hAAAA_AAAA});
    end

    cfg_seg = 4'd5;
    run_mode(3'd5, 6, "R10", 1'b1);
    run_mode(3'd0, 2, "R3", 1'b0);
    cfg_seg = 4'd15;                     // R10 clamp to 14
    run_mode(3'd5, 4, "R10", 1'b0);
    run_mode(3'd0, 2, "R3", 1'b0);
    cfg_seg = 4'd0;
    run_mode(3'd5, 4, "R10", 1'b0);

    // R11 direct forwarding with gaps
    switch_to(3'd6);
    host_valid = 1'b0;
    for (int i = 0; i < 8; i++) push(2'd2, 32'h1234_5000 + 32'(i * 7), "R11");
    mon_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      host_data = 32'h1234_5000 + 32'(i * 7);
      host_valid = 1'b1;
      @(posedge clk); #1;
      if (i % 2 == 1) begin
        host_valid = 1'b0;
        @(posedge clk); #1;
      end
    end
    host_valid = 1'b0;
    @(posedge clk); #1;
    check(exp_q.size() == 0, "R11", 34'(exp_q.size()), '0);
    mon_en = 1'b0;

    run_mode(3'd0, 2, "R3", 1'b0);
    host_valid = 1'b1;
    @(negedge clk);
    check(!host_ready && out_kind == 2'd0, "R11", {out_kind, 31'd0, host_ready}, '0);
    host_valid = 1'b0;

    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule